// File: doc/BRIEF.md
# Successive-Approximation Converter Serial Core

This block is the digital heart of a 12-bit successive-approximation converter, seen from the device side. A host selects it by pulling an active-low select line. The host then supplies a slow serial clock and reads one data bit per clock from a data output that can be tri-stated. Inside, the block drives a trial code onto the converter's weighted DAC and reads back a single comparator decision per step. It resolves one result bit for each serial clock and shifts that bit out at once.

Each access begins with a short sampling window and a null bit, so the host sees four zeros ahead of the result. The result follows MSB first. If the host keeps clocking, the same word comes back LSB first and is then followed by zeros for as long as the clocks continue. Raising the select line at any point abandons the conversion and returns the block to idle. A host that only wants a few leading bits can therefore stop early.

All inputs are sampled on the system clock `clk`. An edge of the select or serial clock takes effect on the first `clk` edge at which the new level is seen.

Top module: `sar_adc_core`

## Requirements
- R1: When `cs_n` is seen going from high to low, the next `clk` edge sets `dout_oe` to 1, drives `dout` to 0 and loads `trial` with mid-scale (only bit 11 set, 0x800). The sequence starts at slot 0.
- R2: While `cs_n` is high, `dout_oe` is 0 from the following `clk` edge on. Serial clocks given while `cs_n` is high have no effect on `dout_oe`.
- R3: `dout` only moves on a falling edge of `dclk`, and each falling edge advances the output by exactly one slot. Slot n is the slot reached after n falling edges since the start.
- R4: Slots 0 to 3 drive 0. Slots 1 and 2 form the sampling window and slot 3 is the null bit.
- R5: Slots 4 to 15 present result bits B11 down to B0, MSB first. Each bit equals the value of `cmp` at the falling edge that enters that slot.
- R6: At each of those 12 falling edges, the trial bit under test is replaced by `cmp` (1 means the input is at or above `trial`), and the next lower trial bit is set to 1. After the twelfth step, `trial` holds the straight-binary code of the input.
- R7: Slots 16 to 26 resend B1 through B11, in that order.
- R8: From slot 27 onward `dout` is 0 for every further falling edge while `cs_n` stays low.
- R9: Raising `cs_n` part-way through a conversion aborts it. The next high-to-low transition starts a fresh conversion that gives a correct result.
- R10: After reset, `dout_oe` and `dout` are 0 and `trial` is 0. A `cs_n` that is already low when reset ends does not start a conversion; a high-to-low transition is needed.
- R11: If the falling edge of `cs_n` and a falling edge of `dclk` are seen at the same `clk` edge, the start wins and that `dclk` edge is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low select; its falling edge starts a conversion, and high means idle |
| dclk | input | 1 | Serial data clock from the host |
| cmp | input | 1 | Comparator decision: 1 when the held input is at or above `trial` |
| trial | output | 12 | Trial code driven to the weighted DAC |
| dout | output | 1 | Serial data bit |
| dout_oe | output | 1 | Output enable for `dout` (0 means high impedance) |

## Verification
The bench goes after the slot boundaries: the step from the null bit into B11, the turn at B0 into the reversed resend, and the step from B11 of the resend into the zero tail. A design that is off by one slot at any of these points would show a shifted or duplicated bit, which the per-clock comparison against a queue of expected bits catches. It uses full-scale and zero inputs and the codes on either side of mid-scale, where a trial step that sets the wrong lower bit, or fails to clear a rejected one, gives a result off by a power of two. It also aborts a conversion part-way through and runs clocks while deselected, which would expose an enable that lingers or a slot counter that keeps running. Finally, it makes the select and serial clock fall together and holds select low through reset, where a design would shift the whole frame by one slot or start a conversion that was never requested.

// File: rtl/sar_if_pkg.sv
package sar_if_pkg;
    // What the output stage drives for the slot being entered
    typedef enum logic [1:0] {
        SRC_ZERO = 2'd0,   // sampling, null bit or trailing zeros
        SRC_LIVE = 2'd1,   // bit resolved on this edge
        SRC_RETX = 2'd2    // stored bit sent again, LSB side first
    } slot_e;
endpackage

// File: rtl/sar_edge_det.sv
// Falling-edge detector for a level sampled on clk.
// Assumes the input is already synchronous to clk.
// The history resets to 0, so a level that is already low after reset gives no edge.
module sar_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic fell_o
);
    logic prev_q;

    // Keep last cycle's level of the input
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig_i;
    end

    assign fell_o = prev_q & ~sig_i;
endmodule

// File: rtl/sar_frame_seq.sv
// Frame sequencer: tracks the slot count of the current access and classifies
// the slot that the next serial falling edge will enter.
// Assumes the edge strobes last one clk cycle each.
module sar_frame_seq
    import sar_if_pkg::*;
#(
    parameter int RES_BITS    = 12,
    parameter int SAMPLE_CLKS = 2,
    localparam int P_FIRST    = SAMPLE_CLKS + 2,
    localparam int P_LAST     = P_FIRST + RES_BITS - 1,
    localparam int P_RETX     = P_LAST + 1,
    localparam int P_ZERO     = P_LAST + RES_BITS,
    localparam int PW         = $clog2(P_ZERO + 1),
    localparam int OW         = $clog2(RES_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          cs_fell,
    input  logic          dclk_fell,
    output logic          start_o,
    output logic          step_o,
    output logic          active_o,
    output logic [PW-1:0] pos_o,
    output slot_e         slot_o,
    output logic [OW-1:0] off_o
);
    logic [PW-1:0] pos_nxt;

    assign start_o = cs_fell;
    assign step_o  = active_o & dclk_fell & ~cs_n & ~cs_fell;
    assign pos_nxt = (pos_o == PW'(P_ZERO)) ? pos_o : pos_o + 1'b1;

    // Classify the slot that the next falling edge enters
    always_comb begin
        slot_o = SRC_ZERO;
        off_o  = '0;
        if (pos_nxt >= PW'(P_FIRST) && pos_nxt <= PW'(P_LAST)) begin
            slot_o = SRC_LIVE;
            off_o  = OW'(pos_nxt - PW'(P_FIRST));
        end else if (pos_nxt >= PW'(P_RETX) && pos_nxt < PW'(P_ZERO)) begin
            slot_o = SRC_RETX;
            off_o  = OW'(pos_nxt - PW'(P_RETX));
        end
    end

    // Access state and saturating slot counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            pos_o    <= '0;
        end else if (cs_n) begin
            active_o <= 1'b0;
        end else if (start_o) begin
            active_o <= 1'b1;
            pos_o    <= '0;
        end else if (step_o) begin
            pos_o    <= pos_nxt;
        end
    end

    // R1
    start_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> (active_o && pos_o == '0));
    // R3
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !dclk_fell) |=> $stable(pos_o));
endmodule

// File: rtl/sar_trial_reg.sv
// Successive-approximation register: holds the DAC trial code.
// Loads mid-scale at a start. On each live step it keeps or drops the bit
// under test according to the comparator, and then sets the next lower bit.
// Assumes cmp is settled for the current trial code when the step arrives.
module sar_trial_reg
    import sar_if_pkg::*;
#(
    parameter int RES_BITS = 12,
    localparam int OW      = $clog2(RES_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                step_i,
    input  slot_e               slot_i,
    input  logic [OW-1:0]       off_i,
    input  logic                cmp_i,
    output logic [RES_BITS-1:0] trial_o
);
    localparam logic [RES_BITS-1:0] MID = {1'b1, {(RES_BITS-1){1'b0}}};

    logic [RES_BITS-1:0] dec_mask;
    logic [RES_BITS-1:0] trial_nxt;

    // Decide the bit under test and arm the next lower one
    always_comb begin
        dec_mask  = MID >> off_i;
        trial_nxt = (trial_o & ~dec_mask)
                  | ({RES_BITS{cmp_i}} & dec_mask)
                  | (dec_mask >> 1);
    end

    // Trial code register
    always_ff @(posedge clk) begin
        if (!rst_n)                              trial_o <= '0;
        else if (start_i)                        trial_o <= MID;
        else if (step_i && slot_i == SRC_LIVE)   trial_o <= trial_nxt;
    end

    // R1
    mid_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> trial_o == MID);
    // R6
    trial_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && slot_i != SRC_LIVE) |=> $stable(trial_o));
endmodule

// File: rtl/sar_dout_sel.sv
// Serial output stage: registers the data bit and its enable.
// The bit is either the live comparator decision, a stored bit sent again,
// or zero. Assumes trial_i holds the final result during the resend slots.
module sar_dout_sel
    import sar_if_pkg::*;
#(
    parameter int RES_BITS = 12,
    localparam int OW      = $clog2(RES_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                start_i,
    input  logic                step_i,
    input  slot_e               slot_i,
    input  logic [OW-1:0]       off_i,
    input  logic                cmp_i,
    input  logic [RES_BITS-1:0] trial_i,
    output logic                dout_o,
    output logic                oe_o
);
    logic [RES_BITS-1:0] shifted;
    logic                retx_bit;

    // Pick the stored bit for a resend slot (B1 first)
    always_comb begin
        shifted  = trial_i >> off_i;
        retx_bit = shifted[1];
    end

    // Data bit and enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_o <= 1'b0;
            oe_o   <= 1'b0;
        end else if (cs_n) begin
            dout_o <= 1'b0;
            oe_o   <= 1'b0;
        end else if (start_i) begin
            dout_o <= 1'b0;
            oe_o   <= 1'b1;
        end else if (step_i) begin
            case (slot_i)
                SRC_LIVE: dout_o <= cmp_i;
                SRC_RETX: dout_o <= retx_bit;
                default:  dout_o <= 1'b0;
            endcase
        end
    end

    // R2
    idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !oe_o);
    // R5
    live_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && slot_i == SRC_LIVE) |=> dout_o == $past(cmp_i));
endmodule

// File: rtl/sar_adc_core.sv
// Top of the successive-approximation serial core.
// Ties together the edge detectors, frame sequencer, trial register and
// output stage. Assumes cs_n and dclk are synchronous to clk.
module sar_adc_core
    import sar_if_pkg::*;
#(
    parameter int RES_BITS    = 12,
    parameter int SAMPLE_CLKS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                dclk,
    input  logic                cmp,
    output logic [RES_BITS-1:0] trial,
    output logic                dout,
    output logic                dout_oe
);
    localparam int P_FIRST = SAMPLE_CLKS + 2;
    localparam int P_ZERO  = P_FIRST + 2 * RES_BITS - 1;
    localparam int PW      = $clog2(P_ZERO + 1);
    localparam int OW      = $clog2(RES_BITS);

    logic          cs_fell, dclk_fell;
    logic          start, step, active;
    logic [PW-1:0] pos;
    slot_e         slot;
    logic [OW-1:0] off;

    sar_edge_det u_cs_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(cs_n), .fell_o(cs_fell)
    );

    sar_edge_det u_dclk_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(dclk), .fell_o(dclk_fell)
    );

    sar_frame_seq #(.RES_BITS(RES_BITS), .SAMPLE_CLKS(SAMPLE_CLKS)) u_seq (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_fell(cs_fell),
        .dclk_fell(dclk_fell), .start_o(start), .step_o(step),
        .active_o(active), .pos_o(pos), .slot_o(slot), .off_o(off)
    );

    sar_trial_reg #(.RES_BITS(RES_BITS)) u_trial (
        .clk(clk), .rst_n(rst_n), .start_i(start), .step_i(step),
        .slot_i(slot), .off_i(off), .cmp_i(cmp), .trial_o(trial)
    );

    sar_dout_sel #(.RES_BITS(RES_BITS)) u_out (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .start_i(start),
        .step_i(step), .slot_i(slot), .off_i(off), .cmp_i(cmp),
        .trial_i(trial), .dout_o(dout), .oe_o(dout_oe)
    );

    // R4
    lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && active && pos < PW'(P_FIRST)) |-> !dout);
    // R8
    tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && active && pos == PW'(P_ZERO)) |-> !dout);
    // R10
    no_spurious_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !start) |=> !dout_oe);
endmodule

// File: tb/tb_sar_adc_core.sv
module tb_sar_adc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b0;
    logic        dclk = 1'b0;
    logic        cmp;
    logic [11:0] vin = 12'd0;
    logic [11:0] trial;
    logic        dout, dout_oe;

    int    checks = 0;
    int    errs = 0;
    bit    done = 1'b0;
    string phase_tag = "";

    always #5 clk = ~clk;

    // Analog stand-in: comparator against the trial code
    assign cmp = (vin >= trial);

    sar_adc_core dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dclk(dclk), .cmp(cmp),
        .trial(trial), .dout(dout), .dout_oe(dout_oe)
    );

    // Reference model: queue of expected bits per slot
    bit m_act = 1'b0;
    bit m_prev_cs = 1'b0;
    bit m_prev_dclk = 1'b0;
    int m_n = 0;
    bit q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 1'b0;
            q.delete();
            m_n = 0;
        end else begin
            if (cs_n) begin
                m_act = 1'b0;
            end else if (m_prev_cs && !cs_n) begin   // R11: start wins over dclk
                m_act = 1'b1;
                m_n = 0;
                q.delete();
                for (int i = 0; i < 4; i++) q.push_back(1'b0);
                for (int b = 11; b >= 0; b--) q.push_back(vin[b]);
                for (int b = 1; b <= 11; b++) q.push_back(vin[b]);
            end else if (m_act && m_prev_dclk && !dclk) begin
                if (q.size() > 0) void'(q.pop_front());
                m_n++;
            end
        end
        m_prev_cs = rst_n ? cs_n : 1'b0;
        m_prev_dclk = rst_n ? dclk : 1'b0;
    end

    function automatic string region(int n);
        if (n < 4)  return "R4";
        if (n < 16) return "R5";
        if (n < 27) return "R7";
        return "R8";
    endfunction

    // Per-clock comparison against the model (R3: one slot per falling edge)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit exp_d;
            exp_d = (q.size() > 0) ? q[0] : 1'b0;
            checks++;
            if (dout_oe !== m_act) begin
                errs++;
                $display("FAIL %s %s dout_oe: actual %0b expected %0b",
                         m_act ? "R1" : "R2", phase_tag, dout_oe, m_act);
            end
            if (m_act) begin
                checks++;
                if (dout !== exp_d) begin
                    errs++;
                    $display("FAIL %s R3 %s slot %0d dout: actual %0b expected %0b",
                             region(m_n), phase_tag, m_n, dout, exp_d);
                end
            end
        end
    end

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic dclk_cycle();
        dclk = 1'b1;
        wait_clk(2);
        dclk = 1'b0;
        wait_clk(2);
    endtask

    task automatic convert(logic [11:0] v, int nclk);
        vin = v;
        cs_n = 1'b0;
        wait_clk(2);
        check("R1 trial at start", int'(trial), 12'h800);
        repeat (nclk) dclk_cycle();
        if (nclk >= 12 + 4) check("R6 final trial", int'(trial), int'(v));
        cs_n = 1'b1;
        wait_clk(3);
        check("R2 oe after deselect", int'(dout_oe), 0);
    endtask

    initial begin
        cs_n = 1'b0;   // R10: held low through reset
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(1);
        check("R10 oe after reset", int'(dout_oe), 0);
        check("R10 dout after reset", int'(dout), 0);
        check("R10 trial after reset", int'(trial), 0);
        phase_tag = "R10";
        repeat (3) dclk_cycle();
        check("R10 no start without edge", int'(dout_oe), 0);
        cs_n = 1'b1;
        wait_clk(3);

        phase_tag = "R6";
        convert(12'hFFF, 30);
        convert(12'h000, 30);
        convert(12'h800, 16);
        convert(12'h7FF, 30);
        convert(12'h4D2, 28);
        convert(12'hA5A, 40);
        convert(12'h001, 30);

        phase_tag = "R9";
        convert(12'h3C7, 7);
        convert(12'hC38, 30);

        phase_tag = "R2";
        cs_n = 1'b1;
        repeat (5) dclk_cycle();
        check("R2 clocks while deselected", int'(dout_oe), 0);

        phase_tag = "R11";
        vin = 12'h5A3;
        dclk = 1'b1;
        wait_clk(2);
        cs_n = 1'b0;
        dclk = 1'b0;
        wait_clk(2);
        repeat (16) dclk_cycle();
        check("R11 final trial", int'(trial), 12'h5A3);
        repeat (14) dclk_cycle();
        cs_n = 1'b1;
        wait_clk(3);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errs++;
            $display("FAIL R3 watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errs);
            $finish;
        end
    end
endmodule